// File: doc/BRIEF.md
# 16-bit Add/Subtract-with-Carry Flag Unit

This block performs a 16-bit add-with-carry or subtract-with-borrow between the contents of an accumulator pair and a 16-bit operand. It also forms the condition byte that such an operation leaves behind. The carry taken into the operation is bit 0 of the incoming condition byte. The sum or difference is formed one bit wider than the data, so the carry or borrow out of the top bit can be read directly. The half-carry and overflow bits come from the same wide result.

The surrounding datapath presents the current pair value, the operand, the current condition byte and the operation select, then pulses the load strobe for one clock. On the next edge the block registers the new pair value and the new condition byte. Both registers keep their contents until the next strobe. Instruction decode, the register file and byte-wide arithmetic belong to other blocks.

Top module: `hlflag_unit`

## Requirements
- R1: With `op_sub` = 0 and `load` = 1, `pair_out` becomes (`pair_in` + `operand` + `cond_in[0]`) mod 65536 on the next rising clock edge.
- R2: With `op_sub` = 1 and `load` = 1, `pair_out` becomes (`pair_in` − `operand` − `cond_in[0]`) mod 65536 on the next rising clock edge.
- R3: The carry bit `cond_out[0]` is set when the add produces a carry out of bit 15, or when the subtract needs a borrow (`pair_in` < `operand` + `cond_in[0]`). Otherwise it is clear.
- R4: The zero bit `cond_out[6]` is set exactly when the 16-bit result is zero. The sign bit `cond_out[7]` equals result bit 15 when the result is nonzero, and is clear otherwise, so the two bits are never both set.
- R5: The half-carry bit `cond_out[4]` equals bit 12 of (`pair_in` xor `operand` xor result).
- R6: The overflow bit `cond_out[2]` is set on two's-complement overflow. For an add this means both operands have the same sign and the result has the other sign. For a subtract it means `pair_in` and `operand` differ in sign and the result's sign differs from that of `pair_in`.
- R7: The subtract bit `cond_out[1]` is set after a subtract and clear after an add.
- R8: Bits 5 and 3 of `cond_out` are always zero. Bits 7 to 1 of `cond_in` have no effect on either output.
- R9: While `load` is 0, `pair_out` and `cond_out` hold their values whatever the other inputs do.
- R10: While `rst_n` is low, `pair_out` and `cond_out` are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously outside the block |
| load | input | 1 | One-cycle strobe that registers a new result |
| op_sub | input | 1 | 0 selects add-with-carry, 1 selects subtract-with-borrow |
| pair_in | input | 16 | Current accumulator pair value |
| operand | input | 16 | Second operand |
| cond_in | input | 8 | Current condition byte; only bit 0 (carry) is used |
| pair_out | output | 16 | Registered result |
| cond_out | output | 8 | Registered condition byte |

## Verification
The checker assumes that `pair_in`, `operand`, `cond_in` and `op_sub` are stable around every clock edge on which `load` is high. It also assumes that reset is released away from an edge. The bench meets both assumptions by changing every input on the falling edge and pulsing `load` for exactly one cycle per operation. The directed cases are chosen to reach each flag boundary: an add wrapping to zero, signed overflow in both directions, a borrow caused only by the incoming carry, a subtract to exactly zero, and an incoming condition byte with its unused bits set.

// File: rtl/hlflag_pkg.sv
package hlflag_pkg;
  // Condition byte layout; positions are fixed because downstream logic decodes them
  localparam int unsigned COND_W   = 8;
  localparam int unsigned BIT_SIGN = 7;
  localparam int unsigned BIT_ZERO = 6;
  localparam int unsigned BIT_RSV5 = 5;
  localparam int unsigned BIT_HALF = 4;
  localparam int unsigned BIT_RSV3 = 3;
  localparam int unsigned BIT_OVF  = 2;
  localparam int unsigned BIT_SUB  = 1;
  localparam int unsigned BIT_CRY  = 0;

  typedef enum logic {
    OP_ADC = 1'b0,
    OP_SBC = 1'b1
  } op_e;
endpackage

// File: rtl/hlflag_arith.sv
module hlflag_arith #(
  parameter int unsigned W = 16
) (
  input  logic         op_sub,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W:0]   wide
);
  import hlflag_pkg::*;

  logic [W:0] a_x, b_x, c_x;

  always_comb begin
    a_x = {1'b0, a};
    b_x = {1'b0, b};
    c_x = {{W{1'b0}}, cin};
    if (op_e'(op_sub) == OP_SBC) wide = a_x - b_x - c_x;
    else                         wide = a_x + b_x + c_x;
  end
endmodule

// File: rtl/hlflag_cond.sv
module hlflag_cond #(
  parameter int unsigned W = 16
) (
  input  logic                              op_sub,
  input  logic [W-1:0]                      a,
  input  logic [W-1:0]                      b,
  input  logic [W:0]                        wide,
  output logic [hlflag_pkg::COND_W-1:0]     cond
);
  import hlflag_pkg::*;

  localparam int unsigned HALF_POS = W - 4;
  localparam int unsigned TOP_POS  = W - 1;

  logic [W-1:0] res, hmix, ov_add, ov_sub;
  logic         zf;

  always_comb begin
    res    = wide[W-1:0];
    hmix   = a ^ b ^ res;
    ov_add = (res ^ b) & (res ^ a);
    ov_sub = (a ^ res) & (a ^ b);
    zf     = (res == '0);
    cond             = '0;
    cond[BIT_CRY]    = wide[W];
    cond[BIT_SUB]    = op_sub;
    cond[BIT_OVF]    = op_sub ? ov_sub[TOP_POS] : ov_add[TOP_POS];
    cond[BIT_HALF]   = hmix[HALF_POS];
    cond[BIT_ZERO]   = zf;
    cond[BIT_SIGN]   = ~zf & res[TOP_POS];
    cond[BIT_RSV5]   = 1'b0;
    cond[BIT_RSV3]   = 1'b0;
  end
endmodule

// File: rtl/hlflag_reg.sv
module hlflag_reg #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] q_nxt;

  always_comb begin
    q_nxt = q;
    if (en) q_nxt = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_nxt;
  end
endmodule

// File: rtl/hlflag_unit.sv
module hlflag_unit #(
  parameter int unsigned W = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          load,
  input  logic                          op_sub,
  input  logic [W-1:0]                  pair_in,
  input  logic [W-1:0]                  operand,
  input  logic [hlflag_pkg::COND_W-1:0] cond_in,
  output logic [W-1:0]                  pair_out,
  output logic [hlflag_pkg::COND_W-1:0] cond_out
);
  import hlflag_pkg::*;

  logic [W:0]        wide;
  logic [COND_W-1:0] cond_nxt;

  hlflag_arith #(.W(W)) u_arith (
    .op_sub (op_sub),
    .a      (pair_in),
    .b      (operand),
    .cin    (cond_in[BIT_CRY]),
    .wide   (wide)
  );

  hlflag_cond #(.W(W)) u_cond (
    .op_sub (op_sub),
    .a      (pair_in),
    .b      (operand),
    .wide   (wide),
    .cond   (cond_nxt)
  );

  hlflag_reg #(.W(W)) u_pair_q (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (load),
    .d     (wide[W-1:0]),
    .q     (pair_out)
  );

  hlflag_reg #(.W(COND_W)) u_cond_q (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (load),
    .d     (cond_nxt),
    .q     (cond_out)
  );
endmodule

// File: rtl/hlflag_checker.sv
module hlflag_checker #(
  parameter int unsigned W = 16
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          load,
  input logic                          op_sub,
  input logic [W-1:0]                  pair_in,
  input logic [W-1:0]                  operand,
  input logic [hlflag_pkg::COND_W-1:0] cond_in,
  input logic [W-1:0]                  pair_out,
  input logic [hlflag_pkg::COND_W-1:0] cond_out
);
  import hlflag_pkg::*;

  logic [W-1:0] add_exp, sub_exp;
  assign add_exp = pair_in + operand + {{(W-1){1'b0}}, cond_in[BIT_CRY]};
  assign sub_exp = pair_in - operand - {{(W-1){1'b0}}, cond_in[BIT_CRY]};

  a_r1_add_result: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !op_sub) |=> pair_out == $past(add_exp));

  a_r2_sub_result: assert property (@(posedge clk) disable iff (!rst_n)
    (load && op_sub) |=> pair_out == $past(sub_exp));

  a_r4_zero_tracks_result: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> cond_out[BIT_ZERO] == (pair_out == '0));

  a_r4_sign_zero_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(cond_out[BIT_SIGN] && cond_out[BIT_ZERO]));

  a_r7_sub_flag: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> cond_out[BIT_SUB] == $past(op_sub));

  a_r8_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (cond_out[BIT_RSV5] == 1'b0) && (cond_out[BIT_RSV3] == 1'b0));

  a_r9_hold_pair: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(pair_out) && $stable(cond_out));

  always_comb begin
    if (!rst_n) begin
      a_r10_reset_clear: assert (pair_out == '0 && cond_out == '0);
    end
  end
endmodule

bind hlflag_unit hlflag_checker #(.W(W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .load     (load),
  .op_sub   (op_sub),
  .pair_in  (pair_in),
  .operand  (operand),
  .cond_in  (cond_in),
  .pair_out (pair_out),
  .cond_out (cond_out)
);

// File: tb/hlflag_unit_test.sv
`timescale 1ns/1ps
module hlflag_unit_test;
  logic        clk;
  logic        rst_n;
  logic        load;
  logic        op_sub;
  logic [15:0] pair_in;
  logic [15:0] operand;
  logic [7:0]  cond_in;
  logic [15:0] pair_out;
  logic [7:0]  cond_out;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done   = 0;

  hlflag_unit uut (
    .clk(clk), .rst_n(rst_n), .load(load), .op_sub(op_sub),
    .pair_in(pair_in), .operand(operand), .cond_in(cond_in),
    .pair_out(pair_out), .cond_out(cond_out)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got %0d cycles expected fewer", cycles);
      finish_run();
    end
  end

  // Apply one operation and check every output field against a model built from R1..R8
  task automatic run_op(input bit sub, input int a, input int b, input int c);
    int cy, res, r16, e_c, e_z, e_s, e_h, e_v;
    bit sa, sb, sr;
    @(negedge clk);
    op_sub = sub; pair_in = a[15:0]; operand = b[15:0]; cond_in = c[7:0];
    load = 1'b1;
    @(negedge clk);
    load = 1'b0;
    cy = c & 1;
    if (sub) begin
      res = a - b - cy;
      e_c = (a < b + cy) ? 1 : 0;
    end else begin
      res = a + b + cy;
      e_c = (res > 65535) ? 1 : 0;
    end
    r16 = res & 16'hFFFF;
    sa = a[15]; sb = b[15]; sr = r16[15];
    e_z = (r16 == 0) ? 1 : 0;
    e_s = (r16 != 0 && sr) ? 1 : 0;
    e_h = ((a ^ b ^ r16) >> 12) & 1;
    if (sub) e_v = (sa != sb && sr != sa) ? 1 : 0;
    else     e_v = (sa == sb && sr != sa) ? 1 : 0;
    chk(sub ? "R2 result" : "R1 result", int'(pair_out), r16);
    chk("R3 carry", int'(cond_out[0]), e_c);
    chk("R4 zero", int'(cond_out[6]), e_z);
    chk("R4 sign", int'(cond_out[7]), e_s);
    chk("R5 half", int'(cond_out[4]), e_h);
    chk("R6 overflow", int'(cond_out[2]), e_v);
    chk("R7 subtract", int'(cond_out[1]), int'(sub));
    chk("R8 reserved", int'({cond_out[5], cond_out[3]}), 0);
  endtask

  task automatic t_reset();
    chk("R10 pair reset", int'(pair_out), 0);
    chk("R10 cond reset", int'(cond_out), 0);
  endtask

  task automatic t_add_cases();
    run_op(1'b0, 16'h1234, 16'h0FCD, 1);  // R1 plain add with half-carry
    run_op(1'b0, 16'hFFFF, 16'h0000, 1);  // R3 R4 wrap to zero
    run_op(1'b0, 16'h7FFF, 16'h0001, 0);  // R6 positive overflow
    run_op(1'b0, 16'h8000, 16'h8000, 0);  // R6 negative overflow, zero and carry
    run_op(1'b0, 16'h0F00, 16'h0100, 0);  // R5 half-carry out of bit 11
  endtask

  task automatic t_sub_cases();
    run_op(1'b1, 16'h5000, 16'h1234, 0);  // R2 plain subtract
    run_op(1'b1, 16'h4321, 16'h4320, 1);  // R4 exact zero via carry-in
    run_op(1'b1, 16'h0000, 16'h0000, 1);  // R3 borrow from carry only
    run_op(1'b1, 16'h8000, 16'h0001, 0);  // R6 overflow
    run_op(1'b1, 16'h7FFF, 16'hFFFF, 0);  // R6 overflow other direction
    run_op(1'b1, 16'h1000, 16'h0001, 0);  // R5 borrow through bit 12
  endtask

  task automatic t_ignored_bits();
    logic [15:0] p0;
    logic [7:0]  c0;
    run_op(1'b0, 16'h2222, 16'h1111, 8'hFE);  // R8 unused bits set, carry clear
    p0 = pair_out; c0 = cond_out;
    chk("R8 upper cond_in ignored", int'(p0), 16'h3333);
    run_op(1'b1, 16'h2222, 16'h1111, 8'h00);
    chk("R8 upper cond_in ignored sub", int'(pair_out), 16'h1111);
    chk("R8 cond byte", int'(c0), 8'h00);
  endtask

  task automatic t_hold();
    logic [15:0] p0;
    logic [7:0]  c0;
    run_op(1'b1, 16'h0100, 16'h0200, 0);
    p0 = pair_out; c0 = cond_out;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      op_sub = ~op_sub; pair_in = 16'h9999 + 16'(i); operand = 16'h1357; cond_in = 8'hFF;
    end
    @(negedge clk);
    chk("R9 pair held", int'(pair_out), int'(p0));
    chk("R9 cond held", int'(cond_out), int'(c0));
  endtask

  initial begin
    rst_n = 1'b0; load = 1'b0; op_sub = 1'b0;
    pair_in = '0; operand = '0; cond_in = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_add_cases();
    t_sub_cases();
    t_ignored_bits();
    t_hold();
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule